// File: doc/BRIEF.md
# Debug access key and reset controller

This block sits behind a debug instruction processor and controls access to privileged device modes. The processor streams eight-byte keys into it. Each complete key is compared with three fixed patterns: one for chip erase, one for non-volatile memory programming and one for user-row programming. A successful comparison sets a bit in a key status register. The processor then pulses a system reset request through a small control/status register port. The pending modes take effect at the moment that request is released.

A chip-erase key starts an erase handshake with the memory controller. When the erase finishes, the device reads as unlocked. A programming key switches programming mode on immediately if the device is unlocked. If the device is locked and a chip-erase key was loaded before the same reset, programming mode switches on once the erase completes. A user-row key grants user-row programming whether the device is locked or not. A link-disable input drops all matched keys and all granted modes.

Top module: `dbg_key_reset_ctrl`

## Requirements
- R1: After reset, `sys_rst_req`, `erase_req`, `nvm_prog_en` and `urow_prog_en` are 0. Register 0x07 reads 0x00, register 0x08 reads 0x00, and register 0x0B reads `lock_in` in bit 0 with every other bit 0.
- R2: The key bytes 0x65 0x73 0x61 0x72 0x45 0x4D 0x56 0x4E, in that order after `key_start`, set bit 3 of register 0x07.
- R3: The key bytes 0x20 0x67 0x6F 0x72 0x50 0x4D 0x56 0x4E set bit 4 of register 0x07. The key bytes 0x75 0x72 0x6F 0x77 0x55 0x4D 0x56 0x4E set bit 5.
- R4: Register 0x07 is unchanged by any of the following: a key that differs from every pattern, a key with fewer than eight bytes, or bytes beyond the eighth. A `key_start` pulse discards any partial key.
- R5: Writing 0x59 to register 0x08 raises `sys_rst_req` one cycle later. `sys_rst_req` stays high until another value is written there. While it is high, register 0x08 reads 0x59 and bit 5 of register 0x0B reads 1; otherwise both read 0.
- R6: A key completed while `sys_rst_req` is high is discarded.
- R7: If key bit 3 is set when the reset request falls, `erase_req` rises one cycle later and holds until `erase_done`. After that, key bit 3 clears and bit 0 of register 0x0B reads 0 even with `lock_in` high.
- R8: If key bit 4 is set at release and the device reads unlocked, bit 3 of register 0x0B and `nvm_prog_en` become 1 and key bit 4 clears. If the device is locked and no erase key is pending, nothing is entered and key bit 4 stays set.
- R9: If erase and programming keys are both loaded before one reset on a locked device, programming mode is entered when `erase_done` arrives, not at release.
- R10: If key bit 5 is set at release, bit 2 of register 0x0B and `urow_prog_en` become 1 and key bit 5 clears, whatever the lock state.
- R11: A cycle with `link_dis` high clears register 0x07, `nvm_prog_en` and `urow_prog_en`.
- R12: Writes to registers 0x07 and 0x0B have no effect, and every other unused index reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_dis | input | 1 | Debug link disabled; drops keys and modes |
| key_start | input | 1 | Begin a new key, discarding partial bytes |
| key_valid | input | 1 | `key_byte` carries a key byte this cycle |
| key_byte | input | 8 | Key byte, first transmitted first |
| csr_idx | input | 4 | Register index |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data for `csr_idx` |
| lock_in | input | 1 | Device lock state from fuses |
| sys_rst_req | output | 1 | System reset request |
| erase_req | output | 1 | Chip erase request to the memory controller |
| erase_done | input | 1 | Erase finished pulse from the memory controller |
| nvm_prog_en | output | 1 | Memory programming mode granted |
| urow_prog_en | output | 1 | User-row programming mode granted |

## Verification
The hardest state to reach is a locked device with both the erase key and the programming key pending, with the erase in progress. In that state, programming entry must wait for the memory controller rather than occur at release. The stimulus loads both keys with the lock held high and issues one reset pulse. It then holds `erase_done` back for several cycles, checks that programming mode is still off, and only then completes the erase. Keys streamed during a held reset, and a key restarted midway, are also driven directly through the byte port.

// File: rtl/dkr_pkg.sv
package dkr_pkg;
  localparam int BYTE_W    = 8;
  localparam int KEY_BYTES = 8;
  localparam int KEY_W     = BYTE_W * KEY_BYTES;
  localparam int IDX_W     = 4;
  localparam int NUM_KEYS  = 3;

  // key slot numbers
  localparam int K_ERASE = 0;
  localparam int K_NVM   = 1;
  localparam int K_UROW  = 2;

  // register indices
  localparam logic [IDX_W-1:0] IDX_KSTAT   = 4'h7;
  localparam logic [IDX_W-1:0] IDX_RSTREQ  = 4'h8;
  localparam logic [IDX_W-1:0] IDX_SYSSTAT = 4'hB;

  localparam logic [BYTE_W-1:0] RST_SIG = 8'h59;

  // key status bit positions
  localparam int KB_ERASE = 3;
  localparam int KB_NVM   = 4;
  localparam int KB_UROW  = 5;
  // system status bit positions
  localparam int SB_RST  = 5;
  localparam int SB_NVM  = 3;
  localparam int SB_UROW = 2;
  localparam int SB_LOCK = 0;

  // first transmitted byte sits in the least significant byte
  localparam logic [KEY_W-1:0] PAT_ERASE = 64'h4E56_4D45_7261_7365;
  localparam logic [KEY_W-1:0] PAT_NVM   = 64'h4E56_4D50_726F_6720;
  localparam logic [KEY_W-1:0] PAT_UROW  = 64'h4E56_4D55_776F_7275;
  localparam logic [NUM_KEYS*KEY_W-1:0] PAT_TABLE = {PAT_UROW, PAT_NVM, PAT_ERASE};

  typedef enum logic [0:0] {SEQ_IDLE, SEQ_ERASE} seq_state_e;
endpackage

// File: rtl/dkr_key_shift.sv
module dkr_key_shift #(
  parameter int BYTE_W    = 8,
  parameter int KEY_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        valid,
  input  logic [BYTE_W-1:0]           byte_in,
  output logic [BYTE_W*KEY_BYTES-1:0] key,
  output logic                        done
);
  localparam int KEY_W = BYTE_W * KEY_BYTES;
  localparam int CNT_W = $clog2(KEY_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(KEY_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             done_q, done_d;
  logic             key_en;

  always_comb begin
    cnt_d  = cnt_q;
    key_d  = key_q;
    done_d = 1'b0;
    key_en = 1'b0;
    if (start) begin
      cnt_d  = '0;
      key_d  = '0;
      key_en = 1'b1;
    end else if (valid && (cnt_q < CNT_FULL)) begin
      key_d  = {byte_in, key_q[KEY_W-1:BYTE_W]};
      cnt_d  = cnt_q + CNT_W'(1);
      done_d = (cnt_q == CNT_LAST);
      key_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_en) key_q <= key_d;
  end

  assign key  = key_q;
  assign done = done_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R4
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == CNT_FULL));
endmodule

// File: rtl/dkr_key_match.sv
module dkr_key_match #(
  parameter int KEY_W    = 64,
  parameter int NUM_KEYS = 3,
  parameter logic [NUM_KEYS*KEY_W-1:0] PATTERNS = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_done,
  input  logic [KEY_W-1:0]    key,
  output logic [NUM_KEYS-1:0] hit
);
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
    assign hit[k] = key_done && (key == PATTERNS[k*KEY_W +: KEY_W]);
  end

  // R4
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/dkr_mode_seq.sv
module dkr_mode_seq
  import dkr_pkg::*;
#(
  parameter int NKEYS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_dis,
  input  logic             key_done,
  input  logic [NKEYS-1:0] hit,
  input  logic             rst_req,
  input  logic             lock_in,
  input  logic             erase_done,
  output logic [NKEYS-1:0] kstat,
  output logic             erase_req,
  output logic             nvm_prog,
  output logic             urow_prog,
  output logic             locked
);
  logic [NKEYS-1:0] kst_q, kst_d;
  logic             rst_d_q;
  seq_state_e       state_q, state_d;
  logic             pend_q, pend_d;
  logic             erased_q, erased_d;
  logic             nvm_q, nvm_d;
  logic             urow_q, urow_d;
  logic             rel, eval, fin;

  assign rel    = rst_d_q & ~rst_req;
  assign eval   = key_done & ~rst_req & ~link_dis;
  assign fin    = (state_q == SEQ_ERASE) & erase_done;
  assign locked = lock_in & ~erased_q;

  always_comb begin
    kst_d    = kst_q;
    state_d  = state_q;
    pend_d   = pend_q;
    erased_d = erased_q;
    nvm_d    = nvm_q;
    urow_d   = urow_q;
    if (eval) kst_d = kst_q | hit;
    if (rel) begin
      if (kst_q[K_UROW]) begin
        urow_d        = 1'b1;
        kst_d[K_UROW] = 1'b0;
      end
      if (kst_q[K_NVM]) begin
        if (!locked) begin
          nvm_d        = 1'b1;
          kst_d[K_NVM] = 1'b0;
        end else if (kst_q[K_ERASE] && (state_q == SEQ_IDLE)) begin
          pend_d = 1'b1;
        end
      end
      if (kst_q[K_ERASE] && (state_q == SEQ_IDLE)) state_d = SEQ_ERASE;
    end
    if (fin) begin
      state_d        = SEQ_IDLE;
      erased_d       = 1'b1;
      kst_d[K_ERASE] = 1'b0;
      if (pend_q) begin
        nvm_d        = 1'b1;
        kst_d[K_NVM] = 1'b0;
        pend_d       = 1'b0;
      end
    end
    if (link_dis) begin
      kst_d  = '0;
      nvm_d  = 1'b0;
      urow_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kst_q    <= '0;
      rst_d_q  <= 1'b0;
      state_q  <= SEQ_IDLE;
      pend_q   <= 1'b0;
      erased_q <= 1'b0;
      nvm_q    <= 1'b0;
      urow_q   <= 1'b0;
    end else begin
      kst_q    <= kst_d;
      rst_d_q  <= rst_req;
      state_q  <= state_d;
      pend_q   <= pend_d;
      erased_q <= erased_d;
      nvm_q    <= nvm_d;
      urow_q   <= urow_d;
    end
  end

  assign kstat     = kst_q;
  assign erase_req = (state_q == SEQ_ERASE);
  assign nvm_prog  = nvm_q;
  assign urow_prog = urow_q;

  // R6
  key_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(kst_q[K_NVM]) || $rose(kst_q[K_ERASE]) || $rose(kst_q[K_UROW]))
      |-> $past(key_done && !rst_req));
  // R7
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) |-> $past(rst_d_q && !rst_req));
  // R7
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_done) |=> erase_req);
  // R9
  nvm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nvm_prog) |-> ($past(rst_d_q && !rst_req) || $past(erase_req && erase_done)));
  // R11
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_dis |=> (kst_q == '0 && !nvm_prog && !urow_prog));
endmodule

// File: rtl/dbg_key_reset_ctrl.sv
module dbg_key_reset_ctrl
  import dkr_pkg::*;
#(
  parameter logic [NUM_KEYS*KEY_W-1:0] PATTERNS = PAT_TABLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_dis,
  input  logic              key_start,
  input  logic              key_valid,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic              csr_we,
  input  logic [BYTE_W-1:0] csr_wdata,
  output logic [BYTE_W-1:0] csr_rdata,
  input  logic              lock_in,
  output logic              sys_rst_req,
  output logic              erase_req,
  input  logic              erase_done,
  output logic              nvm_prog_en,
  output logic              urow_prog_en
);
  logic [KEY_W-1:0]    key_vec;
  logic                key_done;
  logic [NUM_KEYS-1:0] hit;
  logic [NUM_KEYS-1:0] kstat;
  logic                locked;
  logic                rst_req_q, rst_req_d, rst_req_en;

  dkr_key_shift #(.BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES)) shift_i (
    .clk(clk), .rst_n(rst_n), .start(key_start), .valid(key_valid),
    .byte_in(key_byte), .key(key_vec), .done(key_done));

  dkr_key_match #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .PATTERNS(PATTERNS)) match_i (
    .clk(clk), .rst_n(rst_n), .key_done(key_done), .key(key_vec), .hit(hit));

  dkr_mode_seq #(.NKEYS(NUM_KEYS)) seq_i (
    .clk(clk), .rst_n(rst_n), .link_dis(link_dis), .key_done(key_done),
    .hit(hit), .rst_req(rst_req_q), .lock_in(lock_in), .erase_done(erase_done),
    .kstat(kstat), .erase_req(erase_req), .nvm_prog(nvm_prog_en),
    .urow_prog(urow_prog_en), .locked(locked));

  always_comb begin
    rst_req_en = csr_we && (csr_idx == IDX_RSTREQ);
    rst_req_d  = (csr_wdata == RST_SIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rst_req_q <= 1'b0;
    else if (rst_req_en) rst_req_q <= rst_req_d;
  end

  assign sys_rst_req = rst_req_q;

  always_comb begin
    csr_rdata = '0;
    unique case (csr_idx)
      IDX_KSTAT: begin
        csr_rdata[KB_ERASE] = kstat[K_ERASE];
        csr_rdata[KB_NVM]   = kstat[K_NVM];
        csr_rdata[KB_UROW]  = kstat[K_UROW];
      end
      IDX_RSTREQ:  csr_rdata = rst_req_q ? RST_SIG : '0;
      IDX_SYSSTAT: begin
        csr_rdata[SB_RST]  = rst_req_q;
        csr_rdata[SB_NVM]  = nvm_prog_en;
        csr_rdata[SB_UROW] = urow_prog_en;
        csr_rdata[SB_LOCK] = locked;
      end
      default: csr_rdata = '0;
    endcase
  end

  // R5
  rst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(csr_we && csr_idx == IDX_RSTREQ && csr_wdata == RST_SIG));
  // R5
  rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_req && !(csr_we && csr_idx == IDX_RSTREQ)) |=> sys_rst_req);
endmodule

// File: tb/dbg_key_reset_ctrl_tb.sv
module dbg_key_reset_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam logic [63:0] K_ER = 64'h4E56_4D45_7261_7365;
  localparam logic [63:0] K_NV = 64'h4E56_4D50_726F_6720;
  localparam logic [63:0] K_UR = 64'h4E56_4D55_776F_7275;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_dis = 1'b0, key_start = 1'b0, key_valid = 1'b0;
  logic [7:0] key_byte = '0;
  logic [3:0] csr_idx = '0;
  logic csr_we = 1'b0;
  logic [7:0] csr_wdata = '0, csr_rdata;
  logic lock_in = 1'b1, erase_done = 1'b0;
  logic sys_rst_req, erase_req, nvm_prog_en, urow_prog_en;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dbg_key_reset_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .link_dis(link_dis), .key_start(key_start),
    .key_valid(key_valid), .key_byte(key_byte), .csr_idx(csr_idx),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .lock_in(lock_in), .sys_rst_req(sys_rst_req), .erase_req(erase_req),
    .erase_done(erase_done), .nvm_prog_en(nvm_prog_en), .urow_prog_en(urow_prog_en));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] v);
    csr_idx = idx;
    #1 v = csr_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] idx, input logic [7:0] exp);
    logic [7:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    csr_idx = idx; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic send(input logic [63:0] k, input int n, input bit do_start);
    if (do_start) begin
      @(negedge clk); key_start = 1'b1;
      @(negedge clk); key_start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      key_valid = 1'b1; key_byte = k[i*8 +: 8];
      @(negedge clk);
    end
    key_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_reset;
    wr(4'h8, 8'h59);
    chk("R5 rst out", {7'd0, sys_rst_req}, 8'h01);
    chk_reg("R5 rstreq rd", 4'h8, 8'h59);
    wr(4'h8, 8'h00);
    chk("R5 rst released", {7'd0, sys_rst_req}, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  task automatic drop_link;
    @(negedge clk); link_dis = 1'b1;
    @(negedge clk); link_dis = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rst", {7'd0, sys_rst_req}, 8'h00);
    chk("R1 erase", {7'd0, erase_req}, 8'h00);
    chk("R1 modes", {6'd0, nvm_prog_en, urow_prog_en}, 8'h00);
    chk_reg("R1 kstat", 4'h7, 8'h00);
    chk_reg("R1 rstreq", 4'h8, 8'h00);
    chk_reg("R1 sysstat", 4'hB, 8'h01);
  endtask

  task automatic t_nvm_locked;
    send(K_NV, 8, 1'b1);
    chk_reg("R3 nvm key", 4'h7, 8'h10);
    wr(4'h8, 8'h59);
    chk_reg("R5 sysstat rst", 4'hB, 8'h21);
    wr(4'h8, 8'h00);
    repeat (2) @(negedge clk);
    chk_reg("R8 locked no entry", 4'hB, 8'h01);
    chk_reg("R8 key kept", 4'h7, 8'h10);
    drop_link;
    chk_reg("R11 keys cleared", 4'h7, 8'h00);
  endtask

  task automatic t_nvm_unlocked;
    lock_in = 1'b0;
    send(K_NV, 8, 1'b1);
    pulse_reset;
    chk_reg("R8 nvm entered", 4'hB, 8'h08);
    chk("R8 nvm out", {7'd0, nvm_prog_en}, 8'h01);
    chk_reg("R8 key consumed", 4'h7, 8'h00);
    drop_link;
    chk_reg("R11 mode cleared", 4'hB, 8'h00);
    lock_in = 1'b1;
  endtask

  task automatic t_urow;
    send(K_UR, 8, 1'b1);
    chk_reg("R3 urow key", 4'h7, 8'h20);
    pulse_reset;
    chk_reg("R10 urow entered locked", 4'hB, 8'h05);
    chk("R10 urow out", {7'd0, urow_prog_en}, 8'h01);
    chk_reg("R10 key consumed", 4'h7, 8'h00);
    drop_link;
    chk("R11 urow cleared", {7'd0, urow_prog_en}, 8'h00);
  endtask

  task automatic t_bad_keys;
    send(K_ER ^ 64'h0100_0000_0000_0000, 8, 1'b1);
    chk_reg("R4 wrong key", 4'h7, 8'h00);
    send(K_ER, 5, 1'b1);
    chk_reg("R4 short key", 4'h7, 8'h00);
    send(64'hFFFF_FFFF_FFFF_FFFF, 3, 1'b1);
    send(K_NV, 8, 1'b1);
    chk_reg("R4 restart", 4'h7, 8'h10);
    send(K_UR, 8, 1'b0);
    chk_reg("R4 extra bytes ignored", 4'h7, 8'h10);
    drop_link;
  endtask

  task automatic t_key_in_reset;
    wr(4'h8, 8'h59);
    send(K_ER, 8, 1'b1);
    chk_reg("R6 key discarded", 4'h7, 8'h00);
    wr(4'h8, 8'h00);
    repeat (2) @(negedge clk);
    chk("R6 no erase", {7'd0, erase_req}, 8'h00);
    wr(4'h8, 8'h12);
    chk("R5 other value", {7'd0, sys_rst_req}, 8'h00);
  endtask

  task automatic t_ignored;
    wr(4'h7, 8'hFF);
    chk_reg("R12 kstat ro", 4'h7, 8'h00);
    wr(4'hB, 8'hFF);
    chk_reg("R12 sysstat ro", 4'hB, 8'h01);
    chk_reg("R12 unused idx", 4'h3, 8'h00);
  endtask

  task automatic t_erase_combo;
    send(K_ER, 8, 1'b1);
    chk_reg("R2 erase key", 4'h7, 8'h08);
    send(K_NV, 8, 1'b1);
    chk_reg("R2 both keys", 4'h7, 8'h18);
    pulse_reset;
    chk("R7 erase req", {7'd0, erase_req}, 8'h01);
    chk("R9 nvm deferred", {7'd0, nvm_prog_en}, 8'h00);
    repeat (5) @(negedge clk);
    chk("R7 erase held", {7'd0, erase_req}, 8'h01);
    chk_reg("R7 still locked", 4'hB, 8'h01);
    erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
    chk("R7 erase drop", {7'd0, erase_req}, 8'h00);
    chk_reg("R9 unlocked and nvm", 4'hB, 8'h08);
    chk_reg("R7 keys consumed", 4'h7, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_nvm_locked;
    t_nvm_unlocked;
    t_urow;
    t_bad_keys;
    t_key_in_reset;
    t_ignored;
    t_erase_combo;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule